// File: doc/BRIEF.md
# ISA I/O Recovery Delay Timer

This block holds back the address-latch strobe of the next ISA I/O cycle until the bus has been idle long enough after the previous I/O command. The host bridge reports the end of each read or write command on `cmd_n`, which rises when the command ends. The block then counts ISA clock edges. It keeps `ready` low until the interval required for the pending cycle has passed. The bridge must not let the address-latch strobe fall while `ready` is low.

The required interval is a fixed base of five clocks plus an optional extra delay. An 8-bit control register holds two enable bits and two delay codes, one pair for 8-bit cycles and one pair for 16-bit cycles. The width of the pending cycle selects which pair applies. When an access is split into byte sub-cycles by assembly or disassembly, the follow-on pieces skip the recovery wait entirely. The register is sampled when an interval starts, so a write during an interval affects only later intervals.

Top module: `iorec_timer`

## Requirements
- R1: After reset the control register reads 0x56 and `ready` is high.
- R2: Bit 7 of the control register always reads 0, whatever value is written to it.
- R3: When the enable bit for the pending width is clear (bit 6 for 8-bit, bit 2 for 16-bit), the required interval is 5 clocks.
- R4: For 8-bit cycles with bit 6 set, the code in bits 5:3 adds its binary value (1 to 7) to the five clocks, and code 000 adds 8. Totals run from 6 to 13.
- R5: For 16-bit cycles with bit 2 set, the code in bits 1:0 adds its binary value (1 to 3), and code 00 adds 4. Totals run from 6 to 9.
- R6: `cyc_is16` = 1 selects the 16-bit fields and `cyc_is16` = 0 selects the 8-bit fields. The unused pair has no effect on the interval.
- R7: While `cyc_sub` is high, `ready` is high even during a recovery interval.
- R8: A register write made during an interval does not change that interval. It applies from the next interval onward.
- R9: `ready` is low only while an interval is running. Once it rises, it stays high until the next command end. A cycle launched with `cyc_req` while `ready` is high closes the interval.
- R10: The interval starts on the clock edge where `cmd_n` is first seen high after being low. With a required count of N, `ready` is low for the N-1 cycles that follow that edge, so the strobe can fall no earlier than the Nth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ISA clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| ctrl_q | output | 8 | Control register read value |
| cmd_n | input | 1 | I/O read or write command, active low |
| cyc_req | input | 1 | Next I/O cycle requested (strobe about to fall) |
| cyc_is16 | input | 1 | Pending cycle is 16-bit |
| cyc_sub | input | 1 | Pending cycle is a split-access sub-cycle |
| ready | output | 1 | Address-latch strobe may fall |

## Verification
The bench builds the block with its default parameters: a five-clock base, a 3-bit 8-bit code and a 2-bit 16-bit code. With these values the whole range is reachable, from the 5-clock minimum up to the 13-clock maximum, including the all-zeros codes that give the largest delay. Every code value is measured directly, and random register and width pairs cover the cross between the two field pairs. Directed cases cover the sub-cycle bypass and writes that land in the middle of an interval.

// File: rtl/iorec_pkg.sv
package iorec_pkg;
  localparam int CODE8_W  = 3;
  localparam int CODE16_W = 2;

  typedef struct packed {
    logic                rsvd;
    logic                en8;
    logic [CODE8_W-1:0]  code8;
    logic                en16;
    logic [CODE16_W-1:0] code16;
  } ctrl_t;

  // extra clocks for an 8-bit code: zero code means the largest step
  function automatic int unsigned extra8(input logic [CODE8_W-1:0] c);
    return (c == '0) ? (1 << CODE8_W) : int'(c);
  endfunction

  // extra clocks for a 16-bit code: zero code means the largest step
  function automatic int unsigned extra16(input logic [CODE16_W-1:0] c);
    return (c == '0) ? (1 << CODE16_W) : int'(c);
  endfunction
endpackage

// File: rtl/iorec_ctrl_reg.sv
module iorec_ctrl_reg
  import iorec_pkg::*;
#(
  parameter logic [7:0] RESET_VAL = 8'h56
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output ctrl_t      ctrl
);
  ctrl_t nxt;

  always_comb begin
    nxt      = ctrl_t'(wr_data);
    nxt.rsvd = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= ctrl_t'(RESET_VAL);
      ctrl.rsvd <= 1'b0;
    end else if (wr_en) begin
      ctrl <= nxt;
    end
  end
endmodule

// File: rtl/iorec_need.sv
module iorec_need
  import iorec_pkg::*;
#(
  parameter int BASE_CLKS = 5,
  parameter int CNT_W     = 4
) (
  input  ctrl_t              snap,
  input  logic               is16,
  output logic [CNT_W-1:0]   need
);
  int unsigned total;

  always_comb begin
    total = BASE_CLKS;
    if (is16) begin
      if (snap.en16) total = total + extra16(snap.code16);
    end else begin
      if (snap.en8)  total = total + extra8(snap.code8);
    end
    need = CNT_W'(total);
  end
endmodule

// File: rtl/iorec_counter.sv
module iorec_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             launch,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(1);
    end else if (launch) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/iorec_timer.sv
module iorec_timer
  import iorec_pkg::*;
#(
  parameter int         BASE_CLKS = 5,
  parameter logic [7:0] RESET_VAL = 8'h56,
  localparam int        MAX_NEED  = BASE_CLKS + (1 << CODE8_W),
  localparam int        CNT_W     = $clog2(MAX_NEED + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  input  logic       cmd_n,
  input  logic       cyc_req,
  input  logic       cyc_is16,
  input  logic       cyc_sub,
  output logic       ready
);
  ctrl_t            ctrl;
  ctrl_t            rec_snap;
  logic             cmd_prev;
  logic             rec_start;
  logic             rec_launch;
  logic             rec_busy;
  logic [CNT_W-1:0] rec_cnt;
  logic [CNT_W-1:0] rec_need;

  iorec_ctrl_reg #(.RESET_VAL(RESET_VAL)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl(ctrl)
  );

  assign ctrl_q = 8'(ctrl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_prev <= 1'b1;
      rec_snap <= ctrl_t'(RESET_VAL);
    end else begin
      cmd_prev <= cmd_n;
      if (rec_start) rec_snap <= ctrl;
    end
  end

  assign rec_start = cmd_n & ~cmd_prev;

  iorec_need #(.BASE_CLKS(BASE_CLKS), .CNT_W(CNT_W)) u_need (
    .snap(rec_snap), .is16(cyc_is16), .need(rec_need)
  );

  assign ready      = ~rec_busy | cyc_sub | (rec_cnt >= rec_need);
  assign rec_launch = cyc_req & ready & rec_busy;

  iorec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(rec_start), .launch(rec_launch),
    .busy(rec_busy), .cnt(rec_cnt)
  );
endmodule

// File: rtl/iorec_timer_chk.sv
module iorec_timer_chk #(
  parameter int BASE_CLKS = 5,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_sub,
  input logic             ready,
  input logic [7:0]       ctrl_q,
  input logic             rec_start,
  input logic             rec_busy,
  input logic [CNT_W-1:0] rec_cnt,
  input logic [CNT_W-1:0] rec_need,
  input logic [7:0]       rec_snap
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] == 1'b0);

  // R10
  start_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_start |=> (rec_busy && rec_cnt == CNT_W'(1)));

  // R4
  need_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_need >= CNT_W'(BASE_CLKS)) && (rec_need <= CNT_W'(BASE_CLKS + 8)));

  // R7
  sub_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_sub |-> ready);

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_start |=> $stable(rec_snap));

  // R9
  low_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> rec_busy);
endmodule

bind iorec_timer iorec_timer_chk #(.BASE_CLKS(BASE_CLKS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_sub(cyc_sub), .ready(ready), .ctrl_q(ctrl_q),
  .rec_start(rec_start), .rec_busy(rec_busy), .rec_cnt(rec_cnt),
  .rec_need(rec_need), .rec_snap(8'(rec_snap))
);

// File: tb/iorec_timer_bench.sv
module iorec_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_q;
  logic       cmd_n = 1'b1;
  logic       cyc_req = 1'b0;
  logic       cyc_is16 = 1'b0;
  logic       cyc_sub = 1'b0;
  logic       ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  iorec_timer u_iorec_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q),
    .cmd_n(cmd_n), .cyc_req(cyc_req), .cyc_is16(cyc_is16), .cyc_sub(cyc_sub),
    .ready(ready)
  );

  function automatic int exp_gap(input logic [7:0] r, input bit w16);
    int add;
    add = 0;
    if (w16 && r[2])  add = (r[1:0] == 2'b00) ? 4 : r[1:0];
    if (!w16 && r[6]) add = (r[5:3] == 3'b000) ? 8 : r[5:3];
    return 5 + add;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // ends a command and returns the gap: low samples + 1; optional write mid-way
  task automatic measure(input bit w16, input bit mid_wr, input logic [7:0] mid_v,
                         output int gap);
    int lows;
    lows = 0;
    @(negedge clk);
    cyc_is16 = w16;
    cmd_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cmd_n = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (mid_wr && i == 1) begin wr_en = 1'b1; wr_data = mid_v; end
      else wr_en = 1'b0;
      if (ready) break;
      lows++;
    end
    wr_en = 1'b0;
    gap = lows + 1;
    cyc_req = 1'b1;
    @(negedge clk);
    cyc_req = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int g;
    logic [7:0] r;
    bit w;
    void'($urandom(32'h1d2c));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset reg", ctrl_q, 8'h56);
    check("R1 reset ready", ready, 1);

    write_reg(8'hFF);
    check("R2 rsvd bit", ctrl_q, 8'h7F);

    // R10 default register: 8-bit +2, 16-bit +2
    write_reg(8'h56);
    measure(0, 0, 0, g); check("R10 default 8-bit gap", g, 7);
    measure(1, 0, 0, g); check("R10 default 16-bit gap", g, 7);

    // R3 both disabled
    write_reg(8'h3B);
    measure(0, 0, 0, g); check("R3 8-bit disabled", g, 5);
    measure(1, 0, 0, g); check("R3 16-bit disabled", g, 5);

    // R4 every 8-bit code
    for (int c = 0; c < 8; c++) begin
      write_reg(8'h40 | 8'(c << 3));
      measure(0, 0, 0, g);
      check("R4 8-bit code", g, (c == 0) ? 13 : 5 + c);
    end

    // R5 every 16-bit code
    for (int c = 0; c < 4; c++) begin
      write_reg(8'h04 | 8'(c));
      measure(1, 0, 0, g);
      check("R5 16-bit code", g, (c == 0) ? 9 : 5 + c);
    end

    // R6 width picks the field pair
    write_reg(8'h4D);
    measure(0, 0, 0, g); check("R6 8-bit picks bits 5:3", g, 6);
    measure(1, 0, 0, g); check("R6 16-bit picks bits 1:0", g, 6);

    // R8 write mid-interval
    write_reg(8'h78);
    measure(0, 1, 8'h00, g); check("R8 interval keeps old setting", g, 12);
    check("R8 write landed", ctrl_q, 8'h00);
    measure(0, 0, 0, g); check("R8 next interval new setting", g, 5);

    // R7 sub-cycle bypass
    write_reg(8'h40);
    @(negedge clk);
    cyc_is16 = 1'b0; cmd_n = 1'b0;
    @(negedge clk);
    cmd_n = 1'b1;
    @(negedge clk);
    check("R7 ready low without sub", ready, 0);
    cyc_sub = 1'b1;
    #0.5;
    check("R7 ready high with sub", ready, 1);
    @(negedge clk);
    cyc_sub = 1'b0;
    #0.5;
    check("R7 ready low after sub", ready, 0);
    // R9 wait out, stays high, launch closes
    repeat (12) @(negedge clk);
    check("R9 ready after expiry", ready, 1);
    repeat (5) @(negedge clk);
    check("R9 ready stays high", ready, 1);
    cyc_req = 1'b1;
    @(negedge clk);
    cyc_req = 1'b0;
    @(negedge clk);
    check("R9 idle after launch", ready, 1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      r = 8'($urandom());
      w = 1'($urandom());
      write_reg(r);
      measure(w, 0, 0, g);
      check("R6 random setting", g, exp_gap(r, w));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule